// File: doc/BRIEF.md
# Paging Batch Synchronizer and Codeword Classifier

This block sits behind a bit-recovery stage in a paging receiver. It takes one recovered bit per strobe, looks for a run of alternating bits, then hunts for the 32-bit synchronisation word within a sliding window. Once it has the word, it keeps the batch timing: sixteen codeword slots follow each sync word, two slots per frame, eight frames per batch. It then checks for a fresh sync word at the start of each new batch.

Every codeword that completes is presented for one cycle with its 32 bits, a kind tag (sync, idle, address or message), the frame number (0 to 7) and the slot within that frame. The frame number matters for address words because it carries the low three address bits. A message-open flag is raised by an address word. It stays up across frame and batch boundaries while message words keep arriving, and an idle word clears it.

If two expected sync words in a row are missing, the block pulses a loss indication and starts over from the alternating-bit hunt. The controller has four states:

- **PREAMBLE**: count alternating bits.
- **SEARCH**: slide the window looking for the sync word.
- **BATCH**: collect the sixteen codewords.
- **SYNC_CHK**: test the word at the batch start.

It has these transitions:

- PREAMBLE→SEARCH when the run of alternating bits reaches its length.
- SEARCH→BATCH on a sync match.
- BATCH→SYNC_CHK after slot 15.
- SYNC_CHK→BATCH on a match, or on a first miss.
- SYNC_CHK→PREAMBLE on the second consecutive miss.

Top module: `pocsag_batch_sync`

## Requirements
- R1: While reset is held and right after it, cw_valid, in_sync, in_msg and sync_lost are all 0.
- R2: Sync search begins only after PRE_MIN (32) consecutive alternating bits. A sync word without such a run in front of it produces no codeword output.
- R3: In SEARCH, a 32-bit window within SYNC_TOL (2) bit differences of 0x7CD215D8 is accepted. It is output as a codeword of kind 0 (sync) with frame 0 and slot 0, and in_sync goes to 1. Three differences are not accepted.
- R4: After a sync word, the k-th following codeword (k = 0..15) is output with frame k/2 and slot k%2. cw_valid pulses for one cycle, in the cycle after the strobe that carried the codeword's 32nd bit. Bits arrive most significant first.
- R5: Kind codes: the word 0x7A89C197 is idle (1). Any other word with bit 31 = 0 is address (2). Any other word with bit 31 = 1 is message (3).
- R6: in_msg is set by an address word and stays set through message words, including across frame and batch boundaries. It is cleared by an idle word or by loss of sync.
- R7: The word at each batch start is compared with the same tolerance. A match is output as a sync codeword and clears the miss count. A single miss outputs nothing for that position, and the next sixteen slots keep their timing.
- R8: A miss at two consecutive batch starts gives a one-cycle sync_lost pulse and drops in_sync and in_msg. No codeword follows until a new alternating run and sync word have been received.
- R9: Cycles with rx_valid low neither advance the timing nor produce output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Recovered data bit |
| rx_valid | input | 1 | Strobe marking rx_bit as a new bit |
| cw_valid | output | 1 | One-cycle pulse for a completed codeword |
| cw_data | output | 32 | Codeword bits, first received in bit 31 |
| cw_type | output | 2 | 0 sync, 1 idle, 2 address, 3 message |
| cw_frame | output | 3 | Frame number of the codeword |
| cw_slot | output | 1 | Slot within the frame |
| in_sync | output | 1 | Batch timing is held |
| in_msg | output | 1 | A call with message words is open |
| sync_lost | output | 1 | One-cycle pulse on loss of synchronisation |

## Verification
The bench sends a message that starts in the last slot of one batch and continues after the following sync word. A design that clears the message flag at the batch boundary, or mislabels the resumed words, shows the wrong flag or kind in the captured records. It also feeds sync words with exactly two and exactly three flipped bits, both at a batch start and during search, to pin down the tolerance edge. An off-by-one there either loses lock on a legal word or accepts a bad one. A single miss followed by a good sync must not lose lock, while two misses in a row must. A miss counter that never clears, or one that trips on the first miss, is exposed by that pair. Strobes with gaps, including a long stall inside a codeword, catch timing that counts clock cycles instead of bits.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam logic [31:0] SYNC_WORD = 32'h7CD2_15D8;
    localparam logic [31:0] IDLE_WORD = 32'h7A89_C197;

    typedef enum logic [1:0] {
        CW_SYNC = 2'd0,
        CW_IDLE = 2'd1,
        CW_ADDR = 2'd2,
        CW_MSG  = 2'd3
    } cw_kind_e;

    typedef enum logic [1:0] {
        ST_PREAMBLE,
        ST_SEARCH,
        ST_BATCH,
        ST_SYNC_CHK
    } sync_state_e;
endpackage

// File: rtl/pcs_window.sv
module pcs_window #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] win_q,
    output logic [W-1:0] win_next
);
    assign win_next = {win_q[W-2:0], bit_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (shift_en) begin
            win_q <= win_next;
        end
    end
endmodule

// File: rtl/pcs_corr.sv
module pcs_corr #(
    parameter int         W       = 32,
    parameter int         MAX_ERR = 2,
    parameter logic [W-1:0] PATTERN = '0
) (
    input  logic [W-1:0] word,
    output logic         hit
);
    localparam int ERR_W = $clog2(W + 1);

    logic [W-1:0]     diff;
    logic [ERR_W-1:0] errs;

    assign diff = word ^ PATTERN;

    always_comb begin
        errs = '0;
        for (int i = 0; i < W; i++) begin
            errs = errs + ERR_W'(diff[i]);
        end
    end

    assign hit = (errs <= ERR_W'(MAX_ERR));
endmodule

// File: rtl/pocsag_batch_sync.sv
module pocsag_batch_sync
    import pcs_pkg::*;
#(
    parameter int CW_BITS      = 32,
    parameter int PRE_MIN      = 32,
    parameter int SYNC_TOL     = 2,
    parameter int MISS_LIMIT   = 2,
    parameter int CW_PER_BATCH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_bit,
    input  logic         rx_valid,
    output logic         cw_valid,
    output logic [31:0]  cw_data,
    output logic [1:0]   cw_type,
    output logic [2:0]   cw_frame,
    output logic         cw_slot,
    output logic         in_sync,
    output logic         in_msg,
    output logic         sync_lost
);
    localparam int BIT_W   = $clog2(CW_BITS);
    localparam int IDX_W   = $clog2(CW_PER_BATCH);
    localparam int PRE_W   = $clog2(PRE_MIN + 1);
    localparam int MISS_W  = $clog2(MISS_LIMIT + 1);
    localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(CW_BITS - 1);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(CW_PER_BATCH - 1);
    localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(PRE_MIN - 1);
    localparam logic [PRE_W-1:0]  PRE_SAT  = PRE_W'(PRE_MIN);
    localparam logic [MISS_W-1:0] MISS_END = MISS_W'(MISS_LIMIT - 1);

    sync_state_e state_q, state_d;
    logic [BIT_W-1:0]  bit_cnt_q;
    logic [IDX_W-1:0]  cw_idx_q;
    logic [PRE_W-1:0]  pre_cnt_q;
    logic [MISS_W-1:0] miss_q;

    logic [CW_BITS-1:0] win_q, win_next;
    logic sync_hit, alt, word_done;

    logic        cw_valid_q, sync_lost_q, in_msg_q;
    logic [31:0] cw_data_q;
    cw_kind_e    cw_type_q, word_kind;
    logic [2:0]  cw_frame_q;
    logic        cw_slot_q;

    pcs_window #(.W(CW_BITS)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (rx_valid),
        .bit_in   (rx_bit),
        .win_q    (win_q),
        .win_next (win_next)
    );

    pcs_corr #(.W(CW_BITS), .MAX_ERR(SYNC_TOL), .PATTERN(SYNC_WORD)) u_corr (
        .word (win_next),
        .hit  (sync_hit)
    );

    assign alt       = (win_q[0] != rx_bit);
    assign word_done = rx_valid && (bit_cnt_q == LAST_BIT);

    always_comb begin
        if (win_next == IDLE_WORD)       word_kind = CW_IDLE;
        else if (win_next[CW_BITS-1])    word_kind = CW_MSG;
        else                             word_kind = CW_ADDR;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PREAMBLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PREAMBLE: if (rx_valid && alt && pre_cnt_q >= PRE_LAST) state_d = ST_SEARCH;
            ST_SEARCH:   if (rx_valid && sync_hit) state_d = ST_BATCH;
            ST_BATCH:    if (word_done && cw_idx_q == LAST_IDX) state_d = ST_SYNC_CHK;
            ST_SYNC_CHK: if (word_done) begin
                if (!sync_hit && miss_q == MISS_END) state_d = ST_PREAMBLE;
                else                                 state_d = ST_BATCH;
            end
        endcase
    end

    // bit, slot, run and miss counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            cw_idx_q  <= '0;
            pre_cnt_q <= '0;
            miss_q    <= '0;
        end else begin
            unique case (state_q)
                ST_PREAMBLE: begin
                    bit_cnt_q <= '0;
                    cw_idx_q  <= '0;
                    miss_q    <= '0;
                    if (rx_valid) begin
                        if (alt || pre_cnt_q == '0)
                            pre_cnt_q <= (pre_cnt_q == PRE_SAT) ? pre_cnt_q : pre_cnt_q + 1'b1;
                        else
                            pre_cnt_q <= PRE_W'(1);
                    end
                end
                ST_SEARCH: begin
                    pre_cnt_q <= '0;
                    bit_cnt_q <= '0;
                    cw_idx_q  <= '0;
                end
                ST_BATCH: begin
                    if (rx_valid) begin
                        bit_cnt_q <= word_done ? '0 : bit_cnt_q + 1'b1;
                        if (word_done)
                            cw_idx_q <= (cw_idx_q == LAST_IDX) ? '0 : cw_idx_q + 1'b1;
                    end
                end
                ST_SYNC_CHK: begin
                    if (rx_valid) begin
                        bit_cnt_q <= word_done ? '0 : bit_cnt_q + 1'b1;
                        if (word_done)
                            miss_q <= sync_hit ? '0 : miss_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cw_valid_q  <= 1'b0;
            sync_lost_q <= 1'b0;
            in_msg_q    <= 1'b0;
            cw_data_q   <= '0;
            cw_type_q   <= CW_SYNC;
            cw_frame_q  <= '0;
            cw_slot_q   <= 1'b0;
        end else begin
            cw_valid_q  <= 1'b0;
            sync_lost_q <= 1'b0;
            unique case (state_q)
                ST_PREAMBLE: in_msg_q <= 1'b0;
                ST_SEARCH: begin
                    if (rx_valid && sync_hit) begin
                        cw_valid_q <= 1'b1;
                        cw_data_q  <= win_next;
                        cw_type_q  <= CW_SYNC;
                        cw_frame_q <= '0;
                        cw_slot_q  <= 1'b0;
                    end
                end
                ST_BATCH: begin
                    if (word_done) begin
                        cw_valid_q <= 1'b1;
                        cw_data_q  <= win_next;
                        cw_type_q  <= word_kind;
                        cw_frame_q <= cw_idx_q[IDX_W-1:1];
                        cw_slot_q  <= cw_idx_q[0];
                        if (word_kind == CW_IDLE)      in_msg_q <= 1'b0;
                        else if (word_kind == CW_ADDR) in_msg_q <= 1'b1;
                    end
                end
                ST_SYNC_CHK: begin
                    if (word_done) begin
                        if (sync_hit) begin
                            cw_valid_q <= 1'b1;
                            cw_data_q  <= win_next;
                            cw_type_q  <= CW_SYNC;
                            cw_frame_q <= '0;
                            cw_slot_q  <= 1'b0;
                        end else if (miss_q == MISS_END) begin
                            sync_lost_q <= 1'b1;
                            in_msg_q    <= 1'b0;
                        end
                    end
                end
            endcase
        end
    end

    assign cw_valid  = cw_valid_q;
    assign cw_data   = cw_data_q;
    assign cw_type   = cw_type_q;
    assign cw_frame  = cw_frame_q;
    assign cw_slot   = cw_slot_q;
    assign in_msg    = in_msg_q;
    assign sync_lost = sync_lost_q;
    assign in_sync   = (state_q == ST_BATCH) || (state_q == ST_SYNC_CHK);

    AST_OUT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        cw_valid |-> $past(rx_valid)); // R9
    AST_OUT_ONLY_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        cw_valid |-> in_sync); // R4
    AST_ADDR_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && cw_type == CW_ADDR) |-> (!cw_data[31] && in_msg)); // R5
    AST_IDLE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && cw_type == CW_IDLE) |-> !in_msg); // R6
    AST_MSG_KEEPS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && cw_type == CW_MSG && $past(in_msg)) |-> in_msg); // R6
    AST_LOST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lost |=> !sync_lost); // R8
    AST_LOST_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lost |-> (!in_sync && !in_msg && !cw_valid)); // R8
endmodule

// File: tb/pocsag_batch_sync_bench.sv
module pocsag_batch_sync_bench;
    localparam logic [31:0] SYNC = 32'h7CD2_15D8;
    localparam logic [31:0] IDLE = 32'h7A89_C197;
    localparam logic [31:0] ADR  = 32'h1234_5678;
    localparam logic [31:0] MSGA = 32'h9ABC_DEF1;
    localparam logic [31:0] MSGB = 32'hC001_D00D;
    localparam logic [31:0] ERR2 = 32'h0000_0021;
    localparam logic [31:0] ERR3 = 32'h0000_0007;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b0;
    logic rx_valid = 1'b0;
    logic cw_valid, cw_slot, in_sync, in_msg, sync_lost;
    logic [31:0] cw_data;
    logic [1:0]  cw_type;
    logic [2:0]  cw_frame;

    int errors = 0;
    int checks = 0;

    logic [31:0] cap_data [0:255];
    logic [1:0]  cap_type [0:255];
    logic [2:0]  cap_frame[0:255];
    logic        cap_slot [0:255];
    logic        cap_msg  [0:255];
    int cap_n = 0;
    int lost_n = 0;
    logic [31:0] bw [0:15];

    always #10 clk = ~clk;

    pocsag_batch_sync u_pocsag_batch_sync (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_valid(rx_valid),
        .cw_valid(cw_valid), .cw_data(cw_data), .cw_type(cw_type),
        .cw_frame(cw_frame), .cw_slot(cw_slot), .in_sync(in_sync),
        .in_msg(in_msg), .sync_lost(sync_lost)
    );

    always @(negedge clk) begin
        if (cw_valid && cap_n < 256) begin
            cap_data[cap_n]  <= cw_data;
            cap_type[cap_n]  <= cw_type;
            cap_frame[cap_n] <= cw_frame;
            cap_slot[cap_n]  <= cw_slot;
            cap_msg[cap_n]   <= in_msg;
            cap_n <= cap_n + 1;
        end
        if (sync_lost) lost_n <= lost_n + 1;
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w, input bit stall);
        for (int i = 31; i >= 0; i--) begin
            send_bit(w[i]);
            if (stall && i == 16) repeat (7) @(negedge clk);
        end
    endtask

    task automatic send_preamble(input int n);
        for (int i = 0; i < n; i++) send_bit(~i[0]);
    endtask

    task automatic send_batch(input logic [31:0] s, input bit stall);
        send_word(s, 1'b0);
        for (int k = 0; k < 16; k++) send_word(bw[k], stall);
    endtask

    task automatic settle;
        repeat (3) @(negedge clk);
    endtask

    task automatic fill_idle;
        for (int k = 0; k < 16; k++) bw[k] = IDLE;
    endtask

    task automatic check_entry(input int i, input string req, input logic [1:0] t,
                               input logic [2:0] f, input logic s, input logic [31:0] d, input logic m);
        check(req, "kind",  {30'd0, cap_type[i]}, {30'd0, t});
        check(req, "frame", {29'd0, cap_frame[i]}, {29'd0, f});
        check(req, "slot",  {31'd0, cap_slot[i]}, {31'd0, s});
        check(req, "data",  cap_data[i], d);
        check(req, "msg",   {31'd0, cap_msg[i]}, {31'd0, m});
    endtask

    task automatic t_reset;
        check("R1", "cw_valid in reset", {31'd0, cw_valid}, 32'd0);
        check("R1", "in_sync in reset", {31'd0, in_sync}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        check("R1", "cw_valid", {31'd0, cw_valid}, 32'd0);
        check("R1", "in_sync", {31'd0, in_sync}, 32'd0);
        check("R1", "in_msg", {31'd0, in_msg}, 32'd0);
        check("R1", "sync_lost", {31'd0, sync_lost}, 32'd0);
    endtask

    task automatic t_no_preamble;
        int base = cap_n;
        send_word(SYNC, 1'b0);
        send_word(SYNC, 1'b0);
        settle();
        check("R2", "outputs without preamble", cap_n - base, 0);
        check("R2", "in_sync without preamble", {31'd0, in_sync}, 32'd0);
    endtask

    task automatic t_acquire_frames;
        int base = cap_n;
        fill_idle();
        bw[6] = ADR; bw[7] = MSGA; bw[8] = MSGB; bw[9] = MSGA; bw[10] = IDLE; bw[11] = ADR;
        send_preamble(40);
        send_batch(SYNC, 1'b1);
        settle();
        check("R4", "entries in batch", cap_n - base, 17);
        check("R3", "in_sync after acquire", {31'd0, in_sync}, 32'd1);
        check_entry(base, "R3", 2'd0, 3'd0, 1'b0, SYNC, 1'b0);
        check_entry(base + 1, "R4", 2'd1, 3'd0, 1'b0, IDLE, 1'b0);
        check_entry(base + 7, "R5", 2'd2, 3'd3, 1'b0, ADR, 1'b1);
        check_entry(base + 8, "R6", 2'd3, 3'd3, 1'b1, MSGA, 1'b1);
        check_entry(base + 9, "R6", 2'd3, 3'd4, 1'b0, MSGB, 1'b1);
        check_entry(base + 10, "R4", 2'd3, 3'd4, 1'b1, MSGA, 1'b1);
        check_entry(base + 11, "R6", 2'd1, 3'd5, 1'b0, IDLE, 1'b0);
        check_entry(base + 12, "R5", 2'd2, 3'd5, 1'b1, ADR, 1'b1);
        check_entry(base + 16, "R4", 2'd1, 3'd7, 1'b1, IDLE, 1'b0);
    endtask

    task automatic t_msg_over_batch;
        int base = cap_n;
        fill_idle();
        bw[14] = ADR; bw[15] = MSGA;
        send_batch(SYNC ^ ERR2, 1'b0);
        fill_idle();
        bw[0] = MSGB; bw[1] = MSGA;
        send_batch(SYNC, 1'b0);
        settle();
        check("R7", "entries over two batches", cap_n - base, 34);
        check_entry(base, "R7", 2'd0, 3'd0, 1'b0, SYNC ^ ERR2, 1'b0);
        check_entry(base + 16, "R6", 2'd3, 3'd7, 1'b1, MSGA, 1'b1);
        check_entry(base + 17, "R6", 2'd0, 3'd0, 1'b0, SYNC, 1'b1);
        check_entry(base + 18, "R6", 2'd3, 3'd0, 1'b0, MSGB, 1'b1);
        check_entry(base + 19, "R6", 2'd3, 3'd0, 1'b1, MSGA, 1'b1);
        check_entry(base + 20, "R6", 2'd1, 3'd1, 1'b0, IDLE, 1'b0);
    endtask

    task automatic t_miss_then_loss;
        int base = cap_n;
        int lost0 = lost_n;
        fill_idle();
        send_batch(SYNC ^ ERR3, 1'b0);
        settle();
        check("R7", "single miss keeps slots", cap_n - base, 16);
        check_entry(base, "R7", 2'd1, 3'd0, 1'b0, IDLE, 1'b0);
        check("R7", "single miss no loss", lost_n - lost0, 0);
        check("R7", "single miss in_sync", {31'd0, in_sync}, 32'd1);
        base = cap_n;
        send_batch(SYNC, 1'b0);
        settle();
        check("R7", "good sync after miss", cap_n - base, 17);
        base = cap_n;
        bw[15] = ADR;
        send_batch(SYNC ^ ERR3, 1'b0);
        settle();
        check("R7", "miss after reset count", lost_n - lost0, 0);
        check("R6", "in_msg before loss", {31'd0, in_msg}, 32'd1);
        base = cap_n;
        send_word(SYNC ^ ERR3, 1'b0);
        settle();
        check("R8", "loss pulses", lost_n - lost0, 1);
        check("R8", "in_sync after loss", {31'd0, in_sync}, 32'd0);
        check("R8", "in_msg after loss", {31'd0, in_msg}, 32'd0);
        for (int k = 0; k < 4; k++) send_word(IDLE, 1'b0);
        send_word(SYNC, 1'b0);
        settle();
        check("R8", "no output after loss", cap_n - base, 0);
    endtask

    task automatic t_search_tolerance;
        int base = cap_n;
        send_preamble(40);
        send_word(SYNC ^ ERR3, 1'b0);
        settle();
        check("R3", "three errors rejected", cap_n - base, 0);
        check("R3", "still searching", {31'd0, in_sync}, 32'd0);
        send_preamble(32);
        send_word(SYNC ^ ERR2, 1'b0);
        settle();
        check("R3", "two errors accepted", cap_n - base, 1);
        check_entry(base, "R3", 2'd0, 3'd0, 1'b0, SYNC ^ ERR2, 1'b0);
        check("R3", "in_sync after tolerant hit", {31'd0, in_sync}, 32'd1);
    endtask

    task automatic t_strobe_gap;
        int base = cap_n;
        repeat (50) @(negedge clk);
        check("R9", "no output while strobe low", cap_n - base, 0);
        send_word(MSGA, 1'b1);
        settle();
        check("R9", "one word after gaps", cap_n - base, 1);
        check_entry(base, "R9", 2'd3, 3'd0, 1'b0, MSGA, 1'b0);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_no_preamble();
        t_acquire_frames();
        t_msg_over_batch();
        t_miss_then_loss();
        t_search_tolerance();
        t_strobe_gap();
        finish_run();
    end
endmodule